// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a small fixed-point DSP core. Each cycle it takes an operation code, two signed operands and an accumulator value. It keeps an X/Y operand pair, a read-only product register and the accumulator, and it produces zero and sign flags. Address generation for the operands is done elsewhere. The sequencer feeds already-fetched operand values on `x_i` and `y_i`.

The three multiply operations have a one-step pipeline that software can see. Each one latches a fresh X/Y pair. In the same step, the accumulator is cleared, or it takes in the product of the pair that was held before that step. A dot product is therefore written as one clear-and-load followed by a run of accumulate steps, and one final product move or add drains the last pair. The product register is updated one cycle after X and Y change. A bypass inside the block hands the fresh product to a back-to-back accumulate step, so no idle cycle is needed between steps.

Two more operations write the product into the accumulator, or add it to the accumulator, after a one-bit left shift. This aligns a Q15 x Q15 product to Q31. A plain accumulator load is also provided, so the accumulator can be seeded from outside.

Top module: `mac_pipe_unit`

## Requirements
- R1: While reset is held and after it is released, `acc_o`, `prod_o`, `zero_o` and `neg_o` are all zero until the first operation is issued.
- R2: Operation code 2 (clear-load) sets the accumulator to zero on the next clock edge and latches `x_i`/`y_i` as the new X/Y pair. `prod_o` shows their signed product two edges after the issue edge.
- R3: Operation code 3 (mac-add) adds the held product to the accumulator and latches a new X/Y pair in the same step. The held product is the product of the pair that was latched before this step, including the pair latched in the cycle just before.
- R4: Operation code 4 (mac-sub) subtracts the held product from the accumulator and latches a new X/Y pair in the same step.
- R5: Operation code 5 (product-move) writes the held product, shifted left by one bit, into the accumulator. X and Y are unchanged.
- R6: Operation code 6 (product-add) adds the held product, shifted left by one bit, to the accumulator. X and Y are unchanged.
- R7: After operation codes 2 to 6, `zero_o` is 1 exactly when the new accumulator is zero, and `neg_o` equals its bit 31.
- R8: Operation code 1 (acc-load) copies `acc_i` into the accumulator on the next edge and leaves both flags unchanged.
- R9: Operation codes 0 and 7 leave the accumulator, the flags and the X/Y pair unchanged. `prod_o` changes only to complete a product whose pair was latched in the cycle before.
- R10: X and Y are signed two's-complement values. The accumulator and the shifted product wrap modulo 2^32 with no saturation, so -32768 x -32768 moved with the shift gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code, applied for one cycle |
| x_i | input | 16 | Signed X operand |
| y_i | input | 16 | Signed Y operand |
| acc_i | input | 32 | Value for acc-load |
| acc_o | output | 32 | Accumulator |
| prod_o | output | 32 | Product register (read-only) |
| zero_o | output | 1 | Accumulator-zero flag |
| neg_o | output | 1 | Accumulator-sign flag |

## Verification
The bench builds the unit with its defaults: 16-bit operands, a 32-bit accumulator and the product bypass enabled. With these values, the extreme corner -32768 x -32768 can be reached, along with its shifted form that sets the sign bit. Wrap at 0x7FFFFFFF can be reached through acc-load. Back-to-back accumulate steps exercise the bypass path, and the product there is only one cycle old. A pseudo-random run of all eight codes then mixes pipeline hazards with idle gaps.

// File: rtl/mac_pipe_pkg.sv
package mac_pipe_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_ACC_LD  = 3'd1,
    OP_CLR_LD  = 3'd2,
    OP_MAC_ADD = 3'd3,
    OP_MAC_SUB = 3'd4,
    OP_P_MOVE  = 3'd5,
    OP_P_ADD   = 3'd6,
    OP_RSVD    = 3'd7
  } mac_op_e;

  // operations that latch a new X/Y pair
  function automatic logic op_loads_xy(input logic [2:0] op);
    return (op == OP_CLR_LD) || (op == OP_MAC_ADD) || (op == OP_MAC_SUB);
  endfunction

  // operations that refresh the zero/sign flags
  function automatic logic op_sets_flags(input logic [2:0] op);
    return (op >= OP_CLR_LD) && (op <= OP_P_ADD);
  endfunction

endpackage

// File: rtl/mac_opnd_regs.sv
module mac_opnd_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] y_q,
  output logic              pend_q
);

  logic [DATA_W-1:0] x_d, y_d;
  logic              pend_d;

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    pend_d = load_i;
    if (load_i) begin
      x_d = x_i;
      y_d = y_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load_i) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DATA_W = 16,
  parameter bit FWD_EN = 1'b1,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] x_q,
  input  logic [DATA_W-1:0] y_q,
  input  logic              pend_i,
  output logic [PROD_W-1:0] prod_q,
  output logic [PROD_W-1:0] held_o
);

  logic signed [PROD_W-1:0] mul_w;
  logic        [PROD_W-1:0] prod_d;

  always_comb begin
    mul_w = $signed(x_q) * $signed(y_q);
    prod_d = pend_i ? PROD_W'(mul_w) : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prod_q <= '0;
    else if (pend_i) prod_q <= prod_d;
  end

  generate
    if (FWD_EN) begin : g_bypass
      assign held_o = prod_d;
    end else begin : g_no_bypass
      assign held_o = prod_q;
    end
  endgenerate

endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pipe_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int PROD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PROD_W-1:0] held_i,
  output logic [ACC_W-1:0]  acc_q,
  output logic              zero_q,
  output logic              neg_q
);

  logic [ACC_W-1:0] held_ext, held_sh, acc_d;
  logic             acc_en, flag_en, zero_d, neg_d;

  always_comb begin
    held_ext = ACC_W'($signed(held_i));
    held_sh  = held_ext << 1;
    acc_d    = acc_q;
    acc_en   = 1'b1;
    case (op_i)
      OP_ACC_LD:  acc_d = acc_i;
      OP_CLR_LD:  acc_d = '0;
      OP_MAC_ADD: acc_d = acc_q + held_ext;
      OP_MAC_SUB: acc_d = acc_q - held_ext;
      OP_P_MOVE:  acc_d = held_sh;
      OP_P_ADD:   acc_d = acc_q + held_sh;
      default:    acc_en = 1'b0;
    endcase
    flag_en = op_sets_flags(op_i);
    zero_d  = (acc_d == '0);
    neg_d   = acc_d[ACC_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      neg_q  <= 1'b0;
    end else if (flag_en) begin
      zero_q <= zero_d;
      neg_q  <= neg_d;
    end
  end

endmodule

// File: rtl/mac_pipe_unit.sv
module mac_pipe_unit
  import mac_pipe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter bit FWD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [2*DATA_W-1:0] prod_o,
  output logic              zero_o,
  output logic              neg_o
);

  localparam int PROD_W = 2 * DATA_W;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] x_q, y_q;
  logic              pend;
  logic [PROD_W-1:0] held;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mac_opnd_regs #(.DATA_W(DATA_W)) u_opnd (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (op_loads_xy(op_i)),
    .x_i    (x_i),
    .y_i    (y_i),
    .x_q    (x_q),
    .y_q    (y_q),
    .pend_q (pend)
  );

  mac_mult #(.DATA_W(DATA_W), .FWD_EN(FWD_EN)) u_mult (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .x_q    (x_q),
    .y_q    (y_q),
    .pend_i (pend),
    .prod_q (prod_o),
    .held_o (held)
  );

  mac_acc_unit #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .op_i   (op_i),
    .acc_i  (acc_i),
    .held_i (held),
    .acc_q  (acc_o),
    .zero_q (zero_o),
    .neg_q  (neg_o)
  );

endmodule

// File: rtl/mac_pipe_unit_chk.sv
module mac_pipe_unit_chk
  import mac_pipe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [ACC_W-1:0]  acc_o,
  input logic [2*DATA_W-1:0] prod_o,
  input logic              zero_o,
  input logic              neg_o
);

  localparam int PW = 2 * DATA_W;

  logic signed [PW-1:0] xe, ye;
  logic is_idle;
  assign xe = PW'($signed(x_i));
  assign ye = PW'($signed(y_i));
  assign is_idle = (op_i == OP_IDLE) || (op_i == OP_RSVD);

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CLR_LD) |=> (acc_o == '0) && zero_o);

  // R2
  prod_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_loads_xy($past(op_i, 2)) |-> (prod_o == PW'($past(xe, 2) * $past(ye, 2))));

  // R8
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ACC_LD) |=> (acc_o == $past(acc_i)) && $stable(zero_o) && $stable(neg_o));

  // R7
  flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sets_flags(op_i) |=> (zero_o == (acc_o == '0)) && (neg_o == acc_o[ACC_W-1]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && !op_loads_xy($past(op_i))) |=>
      $stable(acc_o) && $stable(prod_o) && $stable(zero_o) && $stable(neg_o));

endmodule

bind mac_pipe_unit mac_pipe_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/mac_pipe_unit_test.sv
`timescale 1ns/1ps
module mac_pipe_unit_test;
  import mac_pipe_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [15:0] x_i, y_i;
  logic [31:0] acc_i, acc_o, prod_o;
  logic        zero_o, neg_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] acc;
    logic        z;
    logic        n;
    logic [31:0] p;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  exp_item_t it;

  // reference state
  logic signed [31:0] mx, my, mp, macc;
  logic               mpend, mz, mn;

  always #2 clk = ~clk;

  mac_pipe_unit uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .x_i(x_i), .y_i(y_i),
    .acc_i(acc_i), .acc_o(acc_o), .prod_o(prod_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R8";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic [2:0] op, input logic [15:0] x, input logic [15:0] y,
                      input logic [31:0] a, input string tag);
    logic signed [31:0] newp, nacc;
    exp_item_t e;
    @(negedge clk);
    op_i = op; x_i = x; y_i = y; acc_i = a;
    newp = mpend ? (mx * my) : mp;
    nacc = macc;
    case (op)
      3'd1: nacc = a;
      3'd2: nacc = 0;
      3'd3: nacc = macc + newp;
      3'd4: nacc = macc - newp;
      3'd5: nacc = newp <<< 1;
      3'd6: nacc = macc + (newp <<< 1);
      default: ;
    endcase
    if (op >= 3'd2 && op <= 3'd6) begin
      mz = (nacc == 0);
      mn = nacc[31];
    end
    macc = nacc;
    mp = newp;
    mpend = (op >= 3'd2 && op <= 3'd4);
    if (mpend) begin
      mx = 32'($signed(x));
      my = 32'($signed(y));
    end
    e.acc = macc; e.z = mz; e.n = mn; e.p = mp; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      checks++;
      if (acc_o !== it.acc || zero_o !== it.z || neg_o !== it.n || prod_o !== it.p) begin
        fails++;
        $display("FAIL %s: acc=%h z=%b n=%b prod=%h expected acc=%h z=%b n=%b prod=%h",
                 it.tag, acc_o, zero_o, neg_o, prod_o, it.acc, it.z, it.n, it.p);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    op_i = 3'd0; x_i = '0; y_i = '0; acc_i = '0;
    mx = 0; my = 0; mp = 0; macc = 0; mpend = 0; mz = 0; mn = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    checks++;
    if (acc_o !== 0 || prod_o !== 0 || zero_o !== 0 || neg_o !== 0) begin
      fails++;
      $display("FAIL R1: acc=%h prod=%h z=%b n=%b expected all zero", acc_o, prod_o, zero_o, neg_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    checks++;
    if (acc_o !== 0 || prod_o !== 0 || zero_o !== 0 || neg_o !== 0) begin
      fails++;
      $display("FAIL R1: acc=%h prod=%h z=%b n=%b expected all zero", acc_o, prod_o, zero_o, neg_o);
    end

    step(3'd1, 16'h0, 16'h0, 32'h1234_5678, "R8");
    step(3'd0, 16'h0, 16'h0, 32'h0, "R9");
    step(3'd2, 16'd3, 16'd4, 32'h0, "R2");
    step(3'd3, 16'd5, -16'sd6, 32'h0, "R3");  // bypass: adds 12
    step(3'd4, 16'd7, 16'd8, 32'h0, "R4");    // subtracts -30
    step(3'd0, 16'h0, 16'h0, 32'h0, "R9");
    step(3'd5, 16'h0, 16'h0, 32'h0, "R5");    // 56 << 1
    step(3'd6, 16'h0, 16'h0, 32'h0, "R6");
    step(3'd2, 16'h8000, 16'h8000, 32'h0, "R10");
    step(3'd0, 16'h0, 16'h0, 32'h0, "R10");
    step(3'd5, 16'h0, 16'h0, 32'h0, "R10");   // 0x80000000, sign set
    step(3'd1, 16'h0, 16'h0, 32'h7FFF_FFFF, "R8");
    step(3'd3, 16'd1, 16'd1, 32'h0, "R10");   // wraps past 0x7FFFFFFF
    step(3'd7, 16'h55, 16'h66, 32'hDEAD_BEEF, "R9");
    step(3'd0, 16'h11, 16'h22, 32'hCAFE_0000, "R9");
    step(3'd2, 16'h0, 16'h1234, 32'h0, "R7");
    step(3'd4, 16'h0, 16'h0, 32'h0, "R7");    // zero flag stays set
    step(3'd1, 16'h0, 16'h0, 32'hFFFF_FFFF, "R8"); // flags unchanged

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[2:0];
      step(op, lfsr ^ 16'h5A5A, {lfsr[7:0], lfsr[15:8]}, {lfsr, ~lfsr}, tag_of(op));
    end
    step(3'd0, 16'h0, 16'h0, 32'h0, "R9");
    step(3'd0, 16'h0, 16'h0, 32'h0, "R9");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule